// File: doc/BRIEF.md
# Timing Reference Selection Controller

This controller decides where a SONET STS-1 multiplexer takes its timing from and when it must fall back to holdover. Software picks one of three modes: line timing recovered from the STS-1 receive signal, free-run from the internal oscillator, or external timing taken from one of the T1/E1 tributary ports. In external mode two sources can be configured, a first choice and a second choice. Each one names a port or is switched off.

The block takes per-port LOS and AIS flags, the line LOS and AIS flags and a one-second tick. It drives a code for the active timing source, the index of the port in use, a flag showing that the second-choice source is active, and a holdover flag. A failed reference sends the block into holdover. It comes out of holdover only after a reference has stayed healthy, with no break, for a set number of ticks. When the block moves between the two external sources it stays on the new source and does not move back. Any change to the configuration restarts the selection and clears all qualification timers.

Top module: `tref_select`

## Requirements
- R1: While reset is applied, and afterwards while the configuration stays at line mode with both external sources off, the outputs read src_o=3 (holdover), holdover_o=1, port_o=0 and ext_sec_o=0.
- R2: With cfg_mode_i equal to 1 (free-run) or 3, src_o reads 1 (oscillator) and holdover_o stays 0 from the cycle after the mode is applied, whatever the line and port flags show.
- R3: In mode 0 (line), when src_o=0 and line_los_i or line_ais_i is high at a clock edge, src_o becomes 3 and holdover_o becomes 1 after that edge.
- R4: In line mode the block leaves holdover only after the line has been healthy on every cycle while QUAL_SECS ticks arrive, plus one edge. Any cycle with line LOS or AIS restarts the count.
- R5: An external source is valid only when it is enabled, its index is below NUM_PORTS, and its port shows neither LOS nor AIS. A source that is not valid is never selected.
- R6: In mode 2 (external), when the active source stops being valid and the other source is valid, the block moves to the other source at the next edge.
- R7: A move between the two external sources does not revert. The block stays on the second-choice source while that source remains valid, even after the first choice recovers.
- R8: In external mode, when neither source is valid at an edge, the block is in holdover (src_o=3) after that edge.
- R9: To leave external holdover a source must have qualified for QUAL_SECS ticks without a break and must still be valid. The first choice is taken if it has qualified, otherwise the second choice.
- R10: Any change to the mode, enable or index inputs sends the block at the next edge into holdover (line or external mode) or free-run (modes 1 and 3), and clears every qualification count.
- R11: src_o encodes 0 line, 1 oscillator, 2 external port, 3 holdover. When src_o=2, port_o carries the index of the source in use and ext_sec_o is 1 for the second choice. Otherwise port_o=0 and ext_sec_o=0, and holdover_o is 1 exactly when src_o=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_mode_i | input | 2 | Timing mode: 0 line, 1 free-run, 2 external, 3 treated as free-run |
| cfg_pri_en_i | input | 1 | Enables the first-choice external source |
| cfg_pri_port_i | input | $clog2(NUM_PORTS) | Port index of the first-choice source |
| cfg_sec_en_i | input | 1 | Enables the second-choice external source |
| cfg_sec_port_i | input | $clog2(NUM_PORTS) | Port index of the second-choice source |
| port_los_i | input | NUM_PORTS | Loss-of-signal flag for each tributary |
| port_ais_i | input | NUM_PORTS | Alarm-indication flag for each tributary |
| line_los_i | input | 1 | Loss of the STS-1 receive signal |
| line_ais_i | input | 1 | AIS received on the STS-1 line |
| tick_1s_i | input | 1 | One-cycle pulse, once per second |
| src_o | output | 2 | Active timing source code |
| port_o | output | $clog2(NUM_PORTS) | Index of the selected port when src_o=2 |
| ext_sec_o | output | 1 | Second-choice external source is in use |
| holdover_o | output | 1 | Block is in holdover |

## Verification
The assertions assume that the tick is a single-cycle pulse and that the configuration inputs change only at edges the block sees, so that a change is always caught one cycle before its effect. They also rely on the port flags being ignored when an index is out of range. The stimulus drives every input just after the falling edge and pulses the tick on every fourth cycle. It changes the configuration only between scenarios, and it does so once per step. Fault patterns on the line and on the two chosen ports are toggled by a pseudo-random sequence, so that failures, recoveries and breaks in qualification land at many different phases against the tick.

// File: rtl/tref_pkg.sv
package tref_pkg;

    typedef enum logic [1:0] {
        MODE_LOOP = 2'd0,
        MODE_FREE = 2'd1,
        MODE_EXT  = 2'd2,
        MODE_ALT  = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        SRC_LINE = 2'd0,
        SRC_OSC  = 2'd1,
        SRC_PORT = 2'd2,
        SRC_HOLD = 2'd3
    } src_e;

    typedef enum logic [2:0] {
        ST_LOOP_RUN  = 3'd0,
        ST_LOOP_HOLD = 3'd1,
        ST_FREE      = 3'd2,
        ST_EXT_PRI   = 3'd3,
        ST_EXT_SEC   = 3'd4,
        ST_EXT_HOLD  = 3'd5
    } sel_st_e;

    localparam int NUM_REFS = 3;   // line, first choice, second choice

endpackage

// File: rtl/tref_port_check.sv
module tref_port_check #(
    parameter int NUM_PORTS = 28,
    parameter int IDX_W     = $clog2(NUM_PORTS)
) (
    input  logic                 en_i,
    input  logic [IDX_W-1:0]     idx_i,
    input  logic [NUM_PORTS-1:0] los_i,
    input  logic [NUM_PORTS-1:0] ais_i,
    output logic                 ok_o
);

    logic in_range;
    logic fault;

    always_comb begin
        in_range = (int'(idx_i) < NUM_PORTS);
        fault    = 1'b1;
        if (in_range) begin
            fault = los_i[idx_i] | ais_i[idx_i];
        end
        ok_o = en_i & in_range & ~fault;
    end

endmodule

// File: rtl/tref_qual.sv
module tref_qual #(
    parameter int QUAL_SECS = 10
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic valid_i,
    input  logic tick_i,
    output logic qual_o
);

    localparam int CNT_W = $clog2(QUAL_SECS + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(QUAL_SECS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } qual_t;

    qual_t qual_d, qual_q;

    always_comb begin
        qual_d = qual_q;
        if (clear_i || !valid_i) begin
            qual_d.cnt = '0;
        end else if (tick_i && (qual_q.cnt != LIMIT)) begin
            qual_d.cnt = qual_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            qual_q <= '{cnt: '0};
        end else begin
            qual_q <= qual_d;
        end
    end

    assign qual_o = (qual_q.cnt == LIMIT);

endmodule

// File: rtl/tref_fsm.sv
module tref_fsm
    import tref_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_ni,
    input  mode_e   mode_i,
    input  logic    change_i,
    input  logic    line_ok_i,
    input  logic    pri_ok_i,
    input  logic    sec_ok_i,
    input  logic    line_qual_i,
    input  logic    pri_qual_i,
    input  logic    sec_qual_i,
    output sel_st_e state_o
);

    typedef struct packed {
        sel_st_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        if (change_i) begin
            case (mode_i)
                MODE_LOOP: fsm_d.st = ST_LOOP_HOLD;
                MODE_EXT:  fsm_d.st = ST_EXT_HOLD;
                default:   fsm_d.st = ST_FREE;
            endcase
        end else begin
            case (fsm_q.st)
                ST_LOOP_RUN: begin
                    if (!line_ok_i) fsm_d.st = ST_LOOP_HOLD;
                end
                ST_LOOP_HOLD: begin
                    if (line_ok_i && line_qual_i) fsm_d.st = ST_LOOP_RUN;
                end
                ST_EXT_PRI: begin
                    if (!pri_ok_i) fsm_d.st = sec_ok_i ? ST_EXT_SEC : ST_EXT_HOLD;
                end
                ST_EXT_SEC: begin
                    if (!sec_ok_i) fsm_d.st = pri_ok_i ? ST_EXT_PRI : ST_EXT_HOLD;
                end
                ST_EXT_HOLD: begin
                    if (pri_ok_i && pri_qual_i) begin
                        fsm_d.st = ST_EXT_PRI;
                    end else if (sec_ok_i && sec_qual_i) begin
                        fsm_d.st = ST_EXT_SEC;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fsm_q <= '{st: ST_LOOP_HOLD};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state_o = fsm_q.st;

endmodule

// File: rtl/tref_select.sv
module tref_select
    import tref_pkg::*;
#(
    parameter int NUM_PORTS = 28,
    parameter int QUAL_SECS = 10
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic [1:0]                   cfg_mode_i,
    input  logic                         cfg_pri_en_i,
    input  logic [$clog2(NUM_PORTS)-1:0] cfg_pri_port_i,
    input  logic                         cfg_sec_en_i,
    input  logic [$clog2(NUM_PORTS)-1:0] cfg_sec_port_i,
    input  logic [NUM_PORTS-1:0]         port_los_i,
    input  logic [NUM_PORTS-1:0]         port_ais_i,
    input  logic                         line_los_i,
    input  logic                         line_ais_i,
    input  logic                         tick_1s_i,
    output logic [1:0]                   src_o,
    output logic [$clog2(NUM_PORTS)-1:0] port_o,
    output logic                         ext_sec_o,
    output logic                         holdover_o
);

    localparam int IDX_W = $clog2(NUM_PORTS);

    typedef struct packed {
        mode_e            mode;
        logic             pri_en;
        logic [IDX_W-1:0] pri_idx;
        logic             sec_en;
        logic [IDX_W-1:0] sec_idx;
    } cfg_t;

    typedef struct packed {
        cfg_t cfg;
    } top_t;

    top_t    top_d, top_q;
    cfg_t    cfg_in;
    logic    cfg_change;
    logic [NUM_REFS-1:0] ok_vec;
    logic [NUM_REFS-1:0] qual_vec;
    logic             ext_en  [2];
    logic [IDX_W-1:0] ext_idx [2];
    sel_st_e st;

    // Configuration capture and change detection
    always_comb begin
        cfg_in.mode    = mode_e'(cfg_mode_i);
        cfg_in.pri_en  = cfg_pri_en_i;
        cfg_in.pri_idx = cfg_pri_port_i;
        cfg_in.sec_en  = cfg_sec_en_i;
        cfg_in.sec_idx = cfg_sec_port_i;
        cfg_change     = (cfg_in != top_q.cfg);
        top_d          = top_q;
        top_d.cfg      = cfg_in;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            top_q <= '{cfg: '{mode: MODE_LOOP, pri_en: 1'b0, pri_idx: '0,
                              sec_en: 1'b0, sec_idx: '0}};
        end else begin
            top_q <= top_d;
        end
    end

    // Reference health: slot 0 is the line, slots 1 and 2 the external choices
    assign ok_vec[0]  = ~line_los_i & ~line_ais_i;
    assign ext_en[0]  = cfg_in.pri_en;
    assign ext_idx[0] = cfg_in.pri_idx;
    assign ext_en[1]  = cfg_in.sec_en;
    assign ext_idx[1] = cfg_in.sec_idx;

    for (genvar g = 0; g < 2; g++) begin : g_ext
        tref_port_check #(
            .NUM_PORTS(NUM_PORTS),
            .IDX_W    (IDX_W)
        ) u_chk (
            .en_i (ext_en[g]),
            .idx_i(ext_idx[g]),
            .los_i(port_los_i),
            .ais_i(port_ais_i),
            .ok_o (ok_vec[g+1])
        );
    end

    for (genvar g = 0; g < NUM_REFS; g++) begin : g_qual
        tref_qual #(
            .QUAL_SECS(QUAL_SECS)
        ) u_qual (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .clear_i(cfg_change),
            .valid_i(ok_vec[g]),
            .tick_i (tick_1s_i),
            .qual_o (qual_vec[g])
        );
    end

    tref_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .mode_i     (cfg_in.mode),
        .change_i   (cfg_change),
        .line_ok_i  (ok_vec[0]),
        .pri_ok_i   (ok_vec[1]),
        .sec_ok_i   (ok_vec[2]),
        .line_qual_i(qual_vec[0]),
        .pri_qual_i (qual_vec[1]),
        .sec_qual_i (qual_vec[2]),
        .state_o    (st)
    );

    // Output decode from the registered selection state
    always_comb begin
        src_o      = SRC_HOLD;
        port_o     = '0;
        ext_sec_o  = 1'b0;
        holdover_o = 1'b0;
        case (st)
            ST_LOOP_RUN: src_o = SRC_LINE;
            ST_FREE:     src_o = SRC_OSC;
            ST_EXT_PRI: begin
                src_o  = SRC_PORT;
                port_o = top_q.cfg.pri_idx;
            end
            ST_EXT_SEC: begin
                src_o     = SRC_PORT;
                port_o    = top_q.cfg.sec_idx;
                ext_sec_o = 1'b1;
            end
            default: holdover_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/tref_select_chk.sv
module tref_select_chk
    import tref_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [1:0]       cfg_mode_i,
    input logic             line_los_i,
    input logic             line_ais_i,
    input logic [1:0]       src_o,
    input logic [IDX_W-1:0] port_o,
    input logic             ext_sec_o,
    input logic             holdover_o,
    input logic             cfg_change,
    input logic [2:0]       ok_vec,
    input logic [2:0]       qual_vec
);

    // R11
    hold_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        holdover_o == (src_o == SRC_HOLD));

    // R11
    port_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_o != SRC_PORT) |-> (port_o == '0 && !ext_sec_o));

    // R2
    free_no_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_mode_i == MODE_FREE || cfg_mode_i == MODE_ALT) |=> (src_o == SRC_OSC));

    // R3
    line_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_mode_i == MODE_LOOP && src_o == SRC_LINE && (line_los_i || line_ais_i))
        |=> holdover_o);

    // R4
    line_exit_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_mode_i == MODE_LOOP && holdover_o && !(ok_vec[0] && qual_vec[0]))
        |=> holdover_o);

    // R8
    ext_both_bad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_mode_i == MODE_EXT && !ok_vec[1] && !ok_vec[2]) |=> (src_o == SRC_HOLD));

    // R9
    ext_exit_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_mode_i == MODE_EXT && holdover_o && !(ok_vec[1] && qual_vec[1])
         && !(ok_vec[2] && qual_vec[2])) |=> holdover_o);

    // R7
    no_revert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_o == SRC_PORT && ext_sec_o && ok_vec[2] && !cfg_change) |=> ext_sec_o);

    // R10
    cfg_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_change && cfg_mode_i == MODE_EXT) |=> holdover_o);

endmodule

bind tref_select tref_select_chk #(
    .IDX_W($clog2(NUM_PORTS))
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_mode_i(cfg_mode_i),
    .line_los_i(line_los_i),
    .line_ais_i(line_ais_i),
    .src_o     (src_o),
    .port_o    (port_o),
    .ext_sec_o (ext_sec_o),
    .holdover_o(holdover_o),
    .cfg_change(cfg_change),
    .ok_vec    (ok_vec),
    .qual_vec  (qual_vec)
);

// File: tb/sim_tref_select.sv
`timescale 1ns/1ps
module sim_tref_select;

    localparam int NP = 28;
    localparam int QS = 10;
    localparam int IW = $clog2(NP);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic          pen = 1'b0, sen = 1'b0;
    logic [IW-1:0] pidx = '0, sidx = '0;
    logic [NP-1:0] plos = '0, pais = '0;
    logic          llos = 1'b0, lais = 1'b0;
    logic          tick = 1'b0;
    logic [1:0]    src;
    logic [IW-1:0] port;
    logic          esec, hold;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit finished = 0;
    string cur_req = "R1";

    // model state: 0 line run, 1 line hold, 2 free, 3 first, 4 second, 5 ext hold
    int m_st = 1;
    int m_cnt[3] = '{0, 0, 0};
    int m_mode = 0, m_pidx = 0, m_sidx = 0;
    bit m_pen = 0, m_sen = 0;

    always #2.5 clk = ~clk;

    tref_select #(.NUM_PORTS(NP), .QUAL_SECS(QS)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .cfg_mode_i(mode),
        .cfg_pri_en_i(pen), .cfg_pri_port_i(pidx),
        .cfg_sec_en_i(sen), .cfg_sec_port_i(sidx),
        .port_los_i(plos), .port_ais_i(pais),
        .line_los_i(llos), .line_ais_i(lais), .tick_1s_i(tick),
        .src_o(src), .port_o(port), .ext_sec_o(esec), .holdover_o(hold)
    );

    function automatic bit pv(bit en, int idx);
        if (!en || idx >= NP) return 0;
        return !plos[idx] && !pais[idx];
    endfunction

    task automatic model_edge();
        bit chg;
        bit ok[3];
        bit q[3];
        if (!rst_n) begin
            m_st = 1; m_cnt = '{0, 0, 0};
            m_mode = 0; m_pen = 0; m_sen = 0; m_pidx = 0; m_sidx = 0;
            return;
        end
        chg = (int'(mode) != m_mode) || (pen != m_pen) || (sen != m_sen)
              || (int'(pidx) != m_pidx) || (int'(sidx) != m_sidx);
        ok[0] = !llos && !lais;
        ok[1] = pv(pen, int'(pidx));
        ok[2] = pv(sen, int'(sidx));
        for (int i = 0; i < 3; i++) q[i] = (m_cnt[i] >= QS);
        if (chg) begin
            m_st = (mode == 2'd0) ? 1 : (mode == 2'd2) ? 5 : 2;
            m_cnt = '{0, 0, 0};
        end else begin
            case (m_st)
                0: if (!ok[0]) m_st = 1;
                1: if (ok[0] && q[0]) m_st = 0;
                3: if (!ok[1]) m_st = ok[2] ? 4 : 5;
                4: if (!ok[2]) m_st = ok[1] ? 3 : 5;
                5: if (ok[1] && q[1]) m_st = 3; else if (ok[2] && q[2]) m_st = 4;
                default: ;
            endcase
            for (int i = 0; i < 3; i++) begin
                if (!ok[i]) m_cnt[i] = 0;
                else if (tick && m_cnt[i] < QS) m_cnt[i]++;
            end
        end
        m_mode = int'(mode); m_pen = pen; m_sen = sen;
        m_pidx = int'(pidx); m_sidx = int'(sidx);
    endtask

    task automatic compare();
        int e_src, e_port;
        bit e_sec;
        e_src  = (m_st == 0) ? 0 : (m_st == 2) ? 1 : (m_st == 3 || m_st == 4) ? 2 : 3;
        e_port = (m_st == 3) ? m_pidx : (m_st == 4) ? m_sidx : 0;
        e_sec  = (m_st == 4);
        n_chk++;
        if (int'(src) != e_src || int'(port) != e_port || esec != e_sec
            || hold != (e_src == 3)) begin
            n_fail++;
            $display("FAIL %s cyc %0d: src/port/sec/hold = %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                     cur_req, cyc, src, port, esec, hold, e_src, e_port, e_sec, e_src == 3);
        end
    endtask

    task automatic step(int n);
        for (int k = 0; k < n; k++) begin
            tick = (cyc % 4 == 3);
            @(posedge clk);
            model_edge();
            @(negedge clk);
            compare();
            cyc++;
        end
    endtask

    task automatic expect_out(int e_src, int e_port, bit e_sec, string req);
        n_chk++;
        if (int'(src) != e_src || int'(port) != e_port || esec != e_sec
            || hold != (e_src == 3)) begin
            n_fail++;
            $display("FAIL %s: src/port/sec/hold = %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                     req, src, port, esec, hold, e_src, e_port, e_sec, e_src == 3);
        end
    endtask

    task automatic set_ext(bit pe, int pi, bit se, int si);
        mode = 2'd2; pen = pe; pidx = IW'(pi); sen = se; sidx = IW'(si);
    endtask

    initial begin
        int seed;
        seed = 32'h1d2c3b4a;
        // R1 reset state
        step(3);
        expect_out(3, 0, 0, "R1");
        rst_n = 1'b1;
        step(2);
        expect_out(3, 0, 0, "R1");

        // R4 line qualification
        cur_req = "R4";
        step(30);
        expect_out(3, 0, 0, "R4");
        step(20);
        expect_out(0, 0, 0, "R4");

        // R3 line AIS while line-timed
        cur_req = "R3";
        lais = 1'b1; step(1); lais = 1'b0;
        expect_out(3, 0, 0, "R3");
        cur_req = "R4";
        step(20);
        llos = 1'b1; step(1); llos = 1'b0;
        step(30);
        expect_out(3, 0, 0, "R4");
        step(20);
        expect_out(0, 0, 0, "R4");

        // R2 free-run ignores faults; R10 mode change
        cur_req = "R2";
        mode = 2'd1; llos = 1'b1; plos = '1;
        step(1);
        expect_out(1, 0, 0, "R2");
        mode = 2'd3; step(60);
        expect_out(1, 0, 0, "R2");
        llos = 1'b0; plos = '0;

        // R10 external entry, R9 first choice taken
        cur_req = "R10";
        set_ext(1, 5, 1, 20);
        step(1);
        expect_out(3, 0, 0, "R10");
        cur_req = "R9";
        step(50);
        expect_out(2, 5, 0, "R9");

        // R6 switch, R7 no revert
        cur_req = "R6";
        plos[5] = 1'b1; step(1);
        expect_out(2, 20, 1, "R6");
        cur_req = "R7";
        plos[5] = 1'b0; step(60);
        expect_out(2, 20, 1, "R7");
        cur_req = "R6";
        pais[20] = 1'b1; step(1);
        expect_out(2, 5, 0, "R6");

        // R8 both bad, R9 second choice exit
        cur_req = "R8";
        plos[5] = 1'b1; step(1);
        expect_out(3, 0, 0, "R8");
        cur_req = "R9";
        pais[20] = 1'b0; step(50);
        expect_out(2, 20, 1, "R9");
        plos[5] = 1'b0;

        // R5 disabled / out-of-range / AIS sources never chosen
        cur_req = "R5";
        set_ext(0, 5, 1, 30);
        step(60);
        expect_out(3, 0, 0, "R5");
        set_ext(1, 7, 0, 3);
        pais[7] = 1'b1;
        step(60);
        expect_out(3, 0, 0, "R5");
        pais[7] = 1'b0;

        // R10 change clears a partial qualification
        cur_req = "R10";
        set_ext(1, 2, 0, 9);
        step(30);
        sen = 1'b1;
        step(1);
        expect_out(3, 0, 0, "R10");
        step(30);
        expect_out(3, 0, 0, "R10");
        step(20);
        expect_out(2, 2, 0, "R11");

        // R7 R8 random fault pattern in external mode, R3 in line mode
        cur_req = "R7";
        for (int k = 0; k < 2500; k++) begin
            seed = seed ^ (seed << 13); seed = seed ^ (seed >>> 17); seed = seed ^ (seed << 5);
            if ((seed & 15) == 0) plos[2] = ~plos[2];
            if ((seed & 240) == 16) pais[9] = ~pais[9];
            if ((seed & 3840) == 256) llos = ~llos;
            if (k == 1250) begin mode = 2'd0; cur_req = "R3"; end
            step(1);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule